// File: doc/BRIEF.md
# Source-Routed Guaranteed-Throughput Router

This block is a pipelined router for guaranteed-service traffic only. By default it has five ports. Each packet is a series of 34-bit words. Every word carries its own valid bit and its own end-of-packet bit, so packets can be of any length. The first valid word of a packet is the header. The header's path field names the output port for this hop. The router reads the port from the low bits of the path and shifts the path down. The next router then finds its own port in the low bits. Payload words follow their header to the same output until the word marked end-of-packet.

Each input word passes through three register stages:
1. The one-word input queue.
2. Header processing, which registers the routed word and the output port.
3. The crossbar output register.

Between stages 2 and 3, the port number is turned into a one-hot select vector and masked with word validity. The crossbar uses the masked vector.

There is no back-pressure at the block's edge. The router takes one word per port on every clock, whether the word is valid or not. The upstream scheduler must make sure that no two inputs target the same output in the same cycle. Inside the block, the input queue hands words to the header processor through a valid/accept handshake. The header processor always accepts.

Top module: `gtr_router`

## Requirements
- R1: Word layout: bit 33 is end-of-packet, bit 32 is valid, bits 31:27 are end-to-end credits, bits 26:22 are the destination queue, and bits 21:0 are the path. Credits, destination queue and both control bits leave the router unchanged.
- R2: A word sampled at an input on clock edge k appears at the output after edge k+2 (three register stages). The output is not valid after edge k+1.
- R3: A header's output port is path bits [PW-1:0], where PW = clog2(NPORTS), which is 3 by default. The header leaves the router with its path shifted right by PW, and the top bits filled with zeros.
- R4: Payload words go to the port of their own header, unmodified, through the end-of-packet word. A new header that follows at once may pick a different port.
- R5: A valid header with end-of-packet set is a single-word packet. The next valid word on that input is treated as a header.
- R6: Words with the valid bit at 0 are ignored, whatever their other bits hold. They do not change the packet state, and idle words may appear inside a packet.
- R7: A port number of NPORTS or higher (codes 5, 6 and 7 by default) selects no output. Every word of that packet is dropped, and the next packet on that input is routed normally.
- R8: An output that no input selects drives an all-zero word.
- R9: While reset (rst_n low) is held, every output word is zero, whatever is on the inputs.
- R10: Inputs that target different outputs in the same cycle are all delivered in that cycle. No output may be targeted by two inputs in one cycle.
- R11: Each input selects at most one output in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_words | input | NPORTS*34 | Input words, port p at bits [p*34 +: 34] |
| out_words | output | NPORTS*34 | Output words, port p at bits [p*34 +: 34] |

## Verification
Some behaviours are checked by assertions on every cycle:
- each input's select vector has at most one bit set;
- no output is targeted by two inputs;
- an output with its valid bit clear carries all zeros;
- any valid output traces back to a valid input three edges earlier;
- outputs are cleared under reset.

Other behaviours can only be shown by the bench's scenarios, where a scoreboard predicts each word and its port:
- path shifting and port selection;
- payload following its header across gaps;
- back-to-back packets that switch ports;
- header-only packets;
- dropping of out-of-range ports;
- the exact three-edge latency.

// File: rtl/gtr_pkg.sv
package gtr_pkg;
  localparam int WORD_W  = 34;
  localparam int EOP_BIT = 33;
  localparam int VLD_BIT = 32;
  localparam int PATH_W  = 22;
  localparam int CRED_HI = 31;
  localparam int CRED_LO = 27;
  localparam int DQ_HI   = 26;
  localparam int DQ_LO   = 22;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    ST_INIT = 1'b0,
    ST_GT   = 1'b1
  } hpu_state_e;
endpackage

// File: rtl/gtr_in_queue.sv
module gtr_in_queue
  import gtr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t in_word,
  input  logic  deq_accept,
  output word_t q_word,
  output logic  q_valid
);
  word_t slot_q;

  // one-flit slot: refilled whenever empty or drained this cycle
  always_ff @(posedge clk) begin
    if (!rst_n)
      slot_q <= '0;
    else if (!slot_q[VLD_BIT] || deq_accept)
      slot_q <= in_word;
  end

  assign q_word  = slot_q;
  assign q_valid = slot_q[VLD_BIT];
endmodule

// File: rtl/gtr_hpu.sv
module gtr_hpu
  import gtr_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  word_t         q_word,
  input  logic          q_valid,
  output logic          q_accept,
  output word_t         word_o,
  output logic [PW-1:0] port_o,
  output logic          vld_o
);
  hpu_state_e    state_q, state_n;
  logic [PW-1:0] route_q;
  logic [PW-1:0] port_n;
  word_t         word_n;

  // the header processor never stalls its queue
  assign q_accept = 1'b1;

  always_comb begin
    state_n = state_q;
    port_n  = route_q;
    word_n  = q_word;
    if (q_valid) begin
      if (state_q == ST_INIT) begin
        port_n                = q_word[PW-1:0];
        word_n[PATH_W-1:0]    = q_word[PATH_W-1:0] >> PW;
      end
      state_n = q_word[EOP_BIT] ? ST_INIT : ST_GT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      route_q <= '0;
      word_o  <= '0;
      port_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (q_valid && state_q == ST_INIT)
        route_q <= q_word[PW-1:0];
      word_o  <= q_valid ? word_n : '0;
      port_o  <= port_n;
      vld_o   <= q_valid;
    end
  end
endmodule

// File: rtl/gtr_onehot.sv
module gtr_onehot #(
  parameter int NPORTS = 5,
  parameter int PW     = 3
) (
  input  logic [PW-1:0]     code,
  output logic [NPORTS-1:0] vec
);
  // codes at or above NPORTS match no bit and give all zeros
  for (genvar n = 0; n < NPORTS; n++) begin : g_bit
    assign vec[n] = (code == PW'(n));
  end
endmodule

// File: rtl/gtr_xbar.sv
module gtr_xbar
  import gtr_pkg::*;
#(
  parameter int NPORTS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS*WORD_W-1:0]   sw_words,
  input  logic [NPORTS*NPORTS-1:0]   sw_sel,
  output logic [NPORTS*WORD_W-1:0]   out_words
);
  logic [NPORTS*WORD_W-1:0] mux_n;

  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    always_comb begin
      mux_n[o*WORD_W +: WORD_W] = '0;
      for (int i = 0; i < NPORTS; i++) begin
        if (sw_sel[i*NPORTS + o])
          mux_n[o*WORD_W +: WORD_W] = mux_n[o*WORD_W +: WORD_W]
                                      | sw_words[i*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_words <= '0;
    else        out_words <= mux_n;
  end
endmodule

// File: rtl/gtr_router.sv
module gtr_router
  import gtr_pkg::*;
#(
  parameter int NPORTS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*WORD_W-1:0] in_words,
  output logic [NPORTS*WORD_W-1:0] out_words
);
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [NPORTS*WORD_W-1:0] hpu_words;
  logic [NPORTS*NPORTS-1:0] xbar_sel;

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    word_t         q_word;
    logic          q_valid;
    logic          q_accept;
    logic [PW-1:0] port;
    logic          vld;
    logic [NPORTS-1:0] ohe;

    gtr_in_queue u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_word    (in_words[i*WORD_W +: WORD_W]),
      .deq_accept (q_accept),
      .q_word     (q_word),
      .q_valid    (q_valid)
    );

    gtr_hpu #(.PW(PW)) u_hpu (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_word   (q_word),
      .q_valid  (q_valid),
      .q_accept (q_accept),
      .word_o   (hpu_words[i*WORD_W +: WORD_W]),
      .port_o   (port),
      .vld_o    (vld)
    );

    gtr_onehot #(.NPORTS(NPORTS), .PW(PW)) u_ohe (
      .code (port),
      .vec  (ohe)
    );

    // reservation: only valid words may claim an output
    assign xbar_sel[i*NPORTS +: NPORTS] = ohe & {NPORTS{vld}};
  end

  gtr_xbar #(.NPORTS(NPORTS)) u_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_words  (hpu_words),
    .sw_sel    (xbar_sel),
    .out_words (out_words)
  );
endmodule

// File: rtl/gtr_router_chk.sv
module gtr_router_chk
  import gtr_pkg::*;
#(
  parameter int NPORTS = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS*WORD_W-1:0] in_words,
  input logic [NPORTS*WORD_W-1:0] out_words,
  input logic [NPORTS*NPORTS-1:0] xbar_sel
);
  logic [1:0]        since_rst;
  logic [NPORTS-1:0] in_vld, out_vld;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_v
    assign in_vld[p]  = in_words[p*WORD_W + VLD_BIT];
    assign out_vld[p] = out_words[p*WORD_W + VLD_BIT];
  end

  // R9
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (out_words == '0));

  // R2
  latency_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && |out_vld) |-> $past(|in_vld, 3));

  for (genvar i = 0; i < NPORTS; i++) begin : g_row
    // R11
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel[i*NPORTS +: NPORTS]));
  end

  for (genvar o = 0; o < NPORTS; o++) begin : g_col
    logic [NPORTS-1:0] col;
    for (genvar i = 0; i < NPORTS; i++) begin : g_c
      assign col[i] = xbar_sel[i*NPORTS + o];
    end
    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_words[o*WORD_W + VLD_BIT] |-> (out_words[o*WORD_W +: WORD_W] == '0));
  end
endmodule

bind gtr_router gtr_router_chk #(.NPORTS(NPORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_words  (in_words),
  .out_words (out_words),
  .xbar_sel  (xbar_sel)
);

// File: tb/test_gtr_router.sv
module test_gtr_router;
  localparam int NP = 5;
  localparam int W  = 34;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*W-1:0] in_words;
  logic [NP*W-1:0] out_words;
  logic [W-1:0]    in_w [NP];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q [NP][$];
  string        tag_q [NP][$];

  always #2 clk = ~clk;

  always_comb
    for (int p = 0; p < NP; p++) in_words[p*W +: W] = in_w[p];

  gtr_router #(.NPORTS(NP)) i_gtr_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_words  (in_words),
    .out_words (out_words)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] out_of(input int p);
    return out_words[p*W +: W];
  endfunction

  // R3: expected header leaves with path shifted right by 3
  function automatic logic [W-1:0] hop(input logic [W-1:0] h);
    logic [W-1:0] r = h;
    r[21:0] = h[21:0] >> 3;
    return r;
  endfunction

  task automatic push(input int dst, input logic [W-1:0] w, input string tag);
    if (dst < NP) begin
      exp_q[dst].push_back(w);
      tag_q[dst].push_back(tag);
    end
  endtask

  // drives one packet word per cycle; leaves the input on its last word
  task automatic send_pkt(input int src, input int dst, input int npay,
                          input bit gap, input string tag);
    logic [W-1:0] w;
    w = {(npay == 0), 1'b1, 5'($urandom), 5'($urandom), 19'($urandom), 3'(dst)};
    push(dst, hop(w), tag);
    @(negedge clk) in_w[src] = w;
    for (int k = 0; k < npay; k++) begin
      if (gap && k == 1) begin
        // R6: idle word with junk, including eop, must be ignored
        @(negedge clk) in_w[src] = {1'b1, 1'b0, 32'($urandom)};
      end
      w = {(k == npay - 1), 1'b1, 32'($urandom)};
      push(dst, w, tag);
      @(negedge clk) in_w[src] = w;
    end
  endtask

  task automatic idle(input int src, input int n);
    @(negedge clk) in_w[src] = '0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int o = 0; o < NP; o++) begin
        logic [W-1:0] a;
        a = out_of(o);
        if (a[32]) begin
          if (exp_q[o].size() == 0) begin
            check(1'b0, "R11/R7 unexpected word", a, '0);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q[o].pop_front();
            t = tag_q[o].pop_front();
            check(a === e, t, a, e);
          end
        end else begin
          check(a === '0, "R8 idle output not zero", a, '0);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] h;
    for (int p = 0; p < NP; p++) in_w[p] = {2'b11, 32'hDEAD_BEE0 | 32'(p)};

    // R9: junk on inputs while reset is held
    repeat (4) @(negedge clk);
    for (int o = 0; o < NP; o++)
      check(out_of(o) === '0, "R9 output during reset", out_of(o), '0);
    for (int p = 0; p < NP; p++) in_w[p] = '0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: header-only word into port 0, bound for output 3
    h = {1'b1, 1'b1, 5'd9, 5'd17, 19'h1ABCD, 3'd3};
    push(3, hop(h), "R2/R3 single word");
    @(negedge clk) in_w[0] = h;
    @(negedge clk) in_w[0] = '0;
    @(posedge clk) #1;
    check(out_of(3)[32] === 1'b0, "R2 early output", out_of(3), '0);
    @(posedge clk) #1;
    check(out_of(3)[32] === 1'b1, "R2 output after third edge", out_of(3), hop(h));
    repeat (4) @(negedge clk);

    // R10/R1: all inputs at once to distinct outputs
    fork
      begin send_pkt(0, 1, 2, 1'b0, "R10/R1 p0"); idle(0, 0); end
      begin send_pkt(1, 2, 2, 1'b0, "R10/R1 p1"); idle(1, 0); end
      begin send_pkt(2, 3, 2, 1'b0, "R10/R1 p2"); idle(2, 0); end
      begin send_pkt(3, 4, 2, 1'b0, "R10/R1 p3"); idle(3, 0); end
      begin send_pkt(4, 0, 2, 1'b0, "R10/R1 p4"); idle(4, 0); end
    join
    repeat (4) @(negedge clk);

    // R4: back-to-back packets on one input switching outputs
    send_pkt(2, 0, 3, 1'b0, "R4 first packet");
    send_pkt(2, 4, 1, 1'b0, "R4 second packet");
    idle(2, 4);

    // R5: header-only packet then a normal one, no gap
    send_pkt(1, 2, 0, 1'b0, "R5 header only");
    send_pkt(1, 3, 2, 1'b0, "R5 following packet");
    idle(1, 4);

    // R6: idle word inside a packet
    send_pkt(3, 1, 3, 1'b1, "R6 gap in packet");
    idle(3, 4);

    // R7: out-of-range ports drop the packet, then routing resumes
    send_pkt(4, 6, 2, 1'b0, "R7 dropped");
    send_pkt(4, 5, 0, 1'b0, "R7 dropped");
    send_pkt(4, 7, 1, 1'b0, "R7 dropped");
    send_pkt(4, 0, 1, 1'b0, "R7 recovery");
    idle(4, 4);

    // long packets in parallel, swapped ports
    fork
      begin send_pkt(0, 4, 20, 1'b1, "R4/R10 long a"); idle(0, 0); end
      begin send_pkt(4, 0, 20, 1'b0, "R4/R10 long b"); idle(4, 0); end
    join
    repeat (8) @(negedge clk);

    for (int o = 0; o < NP; o++)
      check(exp_q[o].size() == 0, "R4/R7 missing words at end",
            W'(exp_q[o].size()), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule